// File: doc/BRIEF.md
# Interpolation Data-Ready Pulse Inserter

The block turns a data-ready strobe that arrives at the pre-interpolation sample rate into a strobe stream at the interpolated rate. Each input strobe produces one, two or four output strobes. The first output strobe follows the input strobe after one register stage. The remaining strobes are inserted at a programmable spacing, counted in processing-clock cycles. With this spacing, the logic that consumes each interpolated sample has time to finish before the next sample arrives. That logic is either a parallel load of a five-word output register or a sixteen-bit parallel-to-serial conversion.

The block enforces a minimum spacing that depends on the output mode: 5 cycles for parallel output and 16 cycles for serial output. A programmed spacing below the minimum is raised to that minimum, and a configuration-error flag reports the condition. If a new input strobe arrives while inserted strobes are still owed, a sticky overrun flag is set and the sequence restarts from the new strobe. The data path is outside this block.

Top module: `interp_strobe_gen`

## Requirements
- R1: After reset, rdy_o, cfg_err_o and overrun_o are all low.
- R2: Every input strobe on rdy_i produces an output strobe on rdy_o in the next cycle, with exactly one register stage of delay.
- R3: The factor code on factor_i sets the number of output strobes per input strobe: 0 gives 1, 1 gives 2, and 2 or 3 give 4.
- R4: The inserted strobes come exactly E cycles apart, where E is the effective spacing. For an input strobe at cycle t, the output strobes fall at t+1, t+1+E, t+1+2E and t+1+3E, up to the count set by R3, and rdy_o is low in every other cycle.
- R5: With serial_i low, a spacing value below 5 is used as 5. Values of 5 and above are used unchanged.
- R6: With serial_i high, a spacing value below 16 is used as 16. Values of 16 and above are used unchanged.
- R7: cfg_err_o is high in the cycle after one in which spacing_i is below the minimum for the current serial_i setting. In every other cycle it is low.
- R8: factor_i, spacing_i and serial_i are captured with the input strobe. Changing them while a sequence is running has no effect on that sequence.
- R9: An input strobe that arrives while inserted strobes are still owed sets overrun_o, which stays high until reset. The new strobe cancels the old sequence and starts a fresh one.
- R10: An input strobe that arrives after the last strobe of a sequence does not set overrun_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rdy_i | input | 1 | Data-ready strobe at the pre-interpolation rate |
| factor_i | input | 2 | Interpolation factor code: 0 for x1, 1 for x2, 2 or 3 for x4 |
| spacing_i | input | 8 | Spacing between inserted strobes, in clock cycles |
| serial_i | input | 1 | Serial output mode, which selects the minimum of 16 |
| rdy_o | output | 1 | Data-ready strobe at the interpolated rate |
| cfg_err_o | output | 1 | Spacing below the minimum for the current mode, registered |
| overrun_o | output | 1 | Sticky flag: an input strobe arrived while strobes were still owed |

## Verification
The main function is swept over every factor code, both output modes and spacing values on both sides of each minimum (0, 3, 4, 5, 6, 9, 15, 16, 17, 33). For each case, the bench compares the complete strobe pattern against positions it computes from the effective spacing. The values just below, at and just above each minimum separate a clamp that is off by one from a correct one. Comparing the two modes at the same value shows that the mode picks the right minimum. Separate patterns check that settings changed in the middle of a sequence are ignored, that an early strobe sets the sticky overrun flag and restarts the sequence, and that a strobe arriving right after a completed sequence leaves the flag clear.

// File: rtl/interp_strobe_pkg.sv
package interp_strobe_pkg;
  typedef enum logic [1:0] {
    FACT_X1  = 2'd0,
    FACT_X2  = 2'd1,
    FACT_X4  = 2'd2,
    FACT_X4R = 2'd3
  } fact_e;

  localparam int unsigned EXTRA_W = 2;

  // pulses to insert after the aligned one
  function automatic logic [EXTRA_W-1:0] extra_pulses(input fact_e f);
    case (f)
      FACT_X1: extra_pulses = 2'd0;
      FACT_X2: extra_pulses = 2'd1;
      default: extra_pulses = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/interp_spacing_lim.sv
module interp_spacing_lim #(
  parameter int unsigned SPACE_W = 8,
  parameter int unsigned PAR_MIN = 5,
  parameter int unsigned SER_MIN = 16
) (
  input  logic [SPACE_W-1:0] spacing_i,
  input  logic               serial_i,
  output logic [SPACE_W-1:0] eff_o,
  output logic               low_o
);
  localparam logic [SPACE_W-1:0] PAR_MIN_V = SPACE_W'(PAR_MIN);
  localparam logic [SPACE_W-1:0] SER_MIN_V = SPACE_W'(SER_MIN);

  logic [SPACE_W-1:0] min_w;

  always_comb begin
    min_w = serial_i ? SER_MIN_V : PAR_MIN_V;
    low_o = spacing_i < min_w;
    eff_o = low_o ? min_w : spacing_i;
  end
endmodule

// File: rtl/interp_pulse_seq.sv
module interp_pulse_seq
  import interp_strobe_pkg::*;
#(
  parameter int unsigned SPACE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [EXTRA_W-1:0] extra_i,
  input  logic [SPACE_W-1:0] eff_i,
  output logic               pulse_o,
  output logic [EXTRA_W-1:0] rem_o,
  output logic               overrun_o
);
  logic [SPACE_W-1:0] cnt_q, period_q;
  logic [EXTRA_W-1:0] rem_q;
  logic               pulse_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      period_q <= '0;
      rem_q    <= '0;
      pulse_q  <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (start_i) begin
        pulse_q  <= 1'b1;
        rem_q    <= extra_i;
        cnt_q    <= eff_i;
        period_q <= eff_i;
        if (rem_q != '0) ovr_q <= 1'b1;
      end else if (rem_q != '0) begin
        if (cnt_q == SPACE_W'(1)) begin
          pulse_q <= 1'b1;
          rem_q   <= rem_q - 1'b1;
          cnt_q   <= period_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign pulse_o   = pulse_q;
  assign rem_o     = rem_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/interp_strobe_gen.sv
module interp_strobe_gen
  import interp_strobe_pkg::*;
#(
  parameter int unsigned SPACE_W = 8,
  parameter int unsigned PAR_MIN = 5,
  parameter int unsigned SER_MIN = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rdy_i,
  input  logic [1:0]         factor_i,
  input  logic [SPACE_W-1:0] spacing_i,
  input  logic               serial_i,
  output logic               rdy_o,
  output logic               cfg_err_o,
  output logic               overrun_o
);
  logic [SPACE_W-1:0] eff_w;
  logic               low_w;
  logic [EXTRA_W-1:0] rem_w;
  logic               err_q;

  interp_spacing_lim #(
    .SPACE_W(SPACE_W), .PAR_MIN(PAR_MIN), .SER_MIN(SER_MIN)
  ) u_lim (
    .spacing_i(spacing_i),
    .serial_i (serial_i),
    .eff_o    (eff_w),
    .low_o    (low_w)
  );

  interp_pulse_seq #(.SPACE_W(SPACE_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (rdy_i),
    .extra_i  (extra_pulses(fact_e'(factor_i))),
    .eff_i    (eff_w),
    .pulse_o  (rdy_o),
    .rem_o    (rem_w),
    .overrun_o(overrun_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= low_w;
  end

  assign cfg_err_o = err_q;
endmodule

// File: rtl/interp_strobe_gen_chk.sv
module interp_strobe_gen_chk #(
  parameter int unsigned SPACE_W = 8,
  parameter int unsigned PAR_MIN = 5,
  parameter int unsigned SER_MIN = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rdy_i,
  input logic [SPACE_W-1:0] spacing_i,
  input logic               serial_i,
  input logic               rdy_o,
  input logic               cfg_err_o,
  input logic               overrun_o,
  input logic [1:0]         rem_i
);
  // R2
  first_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_i |=> rdy_o);

  // R7
  cfg_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_i || !rdy_i) && $past(rst_ni) |->
      cfg_err_o == ($past(spacing_i) < ($past(serial_i) ? SPACE_W'(SER_MIN) : SPACE_W'(PAR_MIN))));

  // R9
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  // R9
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_i && rem_i != 2'd0) |=> overrun_o);

  // R4
  pulse_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_i && rem_i == 2'd0) |=> !rdy_o);
endmodule

bind interp_strobe_gen interp_strobe_gen_chk #(
  .SPACE_W(SPACE_W), .PAR_MIN(PAR_MIN), .SER_MIN(SER_MIN)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rdy_i    (rdy_i),
  .spacing_i(spacing_i),
  .serial_i (serial_i),
  .rdy_o    (rdy_o),
  .cfg_err_o(cfg_err_o),
  .overrun_o(overrun_o),
  .rem_i    (rem_w)
);

// File: tb/interp_strobe_gen_bench.sv
module interp_strobe_gen_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rdy_i = 1'b0;
  logic [1:0] factor_i = 2'd0;
  logic [7:0] spacing_i = 8'd5;
  logic       serial_i = 1'b0;
  logic       rdy_o, cfg_err_o, overrun_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  interp_strobe_gen u_interp_strobe_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .rdy_i(rdy_i), .factor_i(factor_i),
    .spacing_i(spacing_i), .serial_i(serial_i),
    .rdy_o(rdy_o), .cfg_err_o(cfg_err_o), .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int npulse(input int f);
    return (f == 0) ? 1 : (f == 1) ? 2 : 4;
  endfunction

  function automatic int eff_of(input int sp, input bit ser);
    int m = ser ? 16 : 5;
    return (sp < m) ? m : sp;
  endfunction

  // strobe for one cycle; returns at negedge right after the capturing edge
  task automatic strobe();
    rdy_i = 1'b1;
    @(negedge clk_i);
    rdy_i = 1'b0;
  endtask

  // samples j=0..len after the capturing edge; returns first mismatch index or -1
  task automatic watch(input int n, input int e, input int len,
                       input bit chg, output int bad, output int got);
    bad = -1; got = 0;
    for (int j = 0; j <= len; j++) begin
      bit exp_p;
      if (j > 0) @(negedge clk_i);
      if (chg && j == 1) begin
        factor_i = 2'd0; spacing_i = 8'd30; serial_i = 1'b1;
      end
      exp_p = (j % e == 0) && (j / e < n);
      if (rdy_o) got++;
      if (rdy_o !== exp_p && bad < 0) bad = j;
    end
  endtask

  int bad, got;

  initial begin : watchdog
    #1_500_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int sps[10] = '{0, 3, 4, 5, 6, 9, 15, 16, 17, 33};
    repeat (3) @(negedge clk_i);
    // R1
    chk(rdy_o == 0 && cfg_err_o == 0 && overrun_o == 0, "R1 reset",
        {rdy_o, cfg_err_o, overrun_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R3 R4 R5 R6 R7 R10 sweep
    for (int ser = 0; ser < 2; ser++) begin
      for (int f = 0; f < 4; f++) begin
        for (int s = 0; s < 10; s++) begin
          int e, n, m;
          e = eff_of(sps[s], ser[0]);
          n = npulse(f);
          m = ser ? 16 : 5;
          factor_i = 2'(f); spacing_i = 8'(sps[s]); serial_i = ser[0];
          @(negedge clk_i);
          strobe();
          chk(rdy_o == 1, "R2 aligned strobe", rdy_o, 1);
          chk(cfg_err_o == (sps[s] < m), ser ? "R7 cfg_err serial R6" : "R7 cfg_err parallel R5",
              cfg_err_o, sps[s] < m);
          watch(n, e, 3 * e + 6, 1'b0, bad, got);
          chk(bad < 0, ser ? "R4 R6 pattern" : "R4 R5 pattern", bad, -1);
          chk(got == n, "R3 count", got, n);
          chk(overrun_o == 0, "R10 no overrun", overrun_o, 0);
        end
      end
    end

    // R8 settings changed mid-sequence
    factor_i = 2'd2; spacing_i = 8'd8; serial_i = 1'b0;
    @(negedge clk_i);
    strobe();
    watch(4, 8, 40, 1'b1, bad, got);
    chk(bad < 0 && got == 4, "R8 capture at strobe", got, 4);

    // R10 strobe right after last inserted pulse
    factor_i = 2'd2; spacing_i = 8'd10; serial_i = 1'b0;
    @(negedge clk_i);
    strobe();
    repeat (30) @(negedge clk_i);
    strobe();
    chk(overrun_o == 0, "R10 back-to-back", overrun_o, 0);
    watch(4, 10, 40, 1'b0, bad, got);
    chk(overrun_o == 0, "R10 after second sequence", overrun_o, 0);

    // R9 early strobe restarts and sets sticky flag
    strobe();
    repeat (14) @(negedge clk_i);
    strobe();
    chk(overrun_o == 1, "R9 overrun set", overrun_o, 1);
    watch(4, 10, 45, 1'b0, bad, got);
    chk(bad < 0 && got == 4, "R9 restart pattern", bad, -1);
    chk(overrun_o == 1, "R9 sticky", overrun_o, 1);

    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(overrun_o == 0 && rdy_o == 0, "R1 reset clears", overrun_o, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule